// File: doc/BRIEF.md
# Frame Buffer Rotation Scheduler

This block decides which buffer of a ring of frame buffers the next frame of a memory mover will use. It serves either side of a writer/reader pair. On the writer side it steps through the ring one buffer per finished frame. In dynamic mode it steps over the buffer that the paired reader currently holds, so a frame being read is never overwritten.

On the reader side it picks a buffer each time the local mover begins a frame. In simple mode the pick trails the writer's newest finished buffer by a programmed lag. In dynamic mode the pick is always that newest finished buffer. An optional start-up hold keeps the reader idle until the writer has finished enough frames to cover the lag.

The chosen index is turned into a frame base address by adding the index times a byte stride to a base address. When the frame lock enable is low, the block parks on buffer 0 and ignores all events.

Top module: `frame_ring_sched`

## Requirements
- R1: While reset is held, and right after it, `buf_idx` is 0, `frame_addr` equals `base_addr`, and `start_ok` is 1 in the writer role.
- R2: While `lock_en` is 0, `buf_idx` returns to 0 on the next clock edge and frame events have no effect. `start_ok` is 1 while `lock_en` is 0.
- R3: The ring size N is `num_bufs`, where 0 counts as 1 and values above the parameter `MAX_BUFS` count as `MAX_BUFS`. In the writer role (`role_reader`=0) with simple mode (`dyn_mode`=0), each `frame_done` pulse moves `buf_idx` to (`buf_idx`+1) mod N.
- R4: In the writer role with dynamic mode (`dyn_mode`=1) and N>1, if the next index would equal `peer_idx` (the reader's buffer), the writer advances one more step, modulo N, so the new `buf_idx` never equals that `peer_idx`.
- R5: In the reader role (`role_reader`=1) with simple mode, an accepted `frame_start` sets `buf_idx` to (`peer_idx` − `lag`) mod N, where `peer_idx` is the writer's newest finished buffer.
- R6: In the reader role with dynamic mode, an accepted `frame_start` sets `buf_idx` to `peer_idx`.
- R7: With `wait_writer`=1 in the reader role, `start_ok` stays 0 until the number of `peer_valid` pulses counted since `lock_en` rose reaches `lag`+1. While `start_ok` is 0, `frame_start` leaves `buf_idx` unchanged. A `peer_valid` pulse that arrives in the same cycle as a `frame_start` does not let that `frame_start` through.
- R8: With `wait_writer`=0, `start_ok` is 1 with no wait. In the writer role, `start_ok` is always 1.
- R9: `frame_addr` = `base_addr` + `buf_idx` × `frame_stride`, truncated to 32 bits. It is combinational from the current index.
- R10: An event sampled at a clock edge changes `buf_idx` at that same edge. A writer ignores `frame_start`, and a reader ignores `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Enables frame lock; index held at 0 when low |
| role_reader | input | 1 | 1 selects the reader role, 0 the writer role |
| dyn_mode | input | 1 | 1 selects dynamic mode, 0 simple mode |
| wait_writer | input | 1 | Reader holds off until enough writer frames are done |
| num_bufs | input | 6 | Ring size (0 treated as 1, clamped to MAX_BUFS) |
| lag | input | 5 | Reader lag behind the writer's newest finished buffer |
| base_addr | input | 32 | Address of buffer 0 |
| frame_stride | input | 32 | Bytes between consecutive buffers |
| frame_start | input | 1 | Local mover begins a frame (reader selection point) |
| frame_done | input | 1 | Local mover finished a frame (writer step point) |
| peer_idx | input | 6 | Writer: reader's buffer; reader: writer's newest finished buffer |
| peer_valid | input | 1 | Pulse: paired writer finished a frame |
| buf_idx | output | 6 | Selected buffer index |
| frame_addr | output | 32 | Base address of the selected buffer |
| start_ok | output | 1 | The local mover may start a frame |

## Verification
The conflict that needs care is the reader's start-up hold being released in the same cycle that the mover asks to begin a frame. The bench waits until the fill count is one short of the threshold. It then raises `peer_valid` and `frame_start` together. It expects the index to stay put for that request and `start_ok` to rise one cycle later. A following lone `frame_start` must then select the lagged buffer. The writer's skip rule is also exercised where the step and the wrap coincide, with the reader holding the last buffer of the ring.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;

  localparam int IDX_W  = 6;
  localparam int LAG_W  = 5;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 6;

  // clamp a programmed ring size into 1..max_n
  function automatic logic [IDX_W-1:0] ring_size(input logic [IDX_W-1:0] req,
                                                  input logic [IDX_W-1:0] max_n);
    if (req == '0)
      return {{(IDX_W-1){1'b0}}, 1'b1};
    else if (req > max_n)
      return max_n;
    else
      return req;
  endfunction

  // one step forward around the ring; out-of-range current index restarts at 0
  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] cur,
                                                  input logic [IDX_W-1:0] n);
    logic [IDX_W:0] t;
    t = {1'b0, cur} + {{IDX_W{1'b0}}, 1'b1};
    if (t >= {1'b0, n})
      return '0;
    else
      return t[IDX_W-1:0];
  endfunction

  // (a - b) mod n, with b smaller than 32*n so the sum stays positive
  function automatic logic [IDX_W-1:0] ring_back(input logic [IDX_W-1:0] a,
                                                  input logic [LAG_W-1:0] b,
                                                  input logic [IDX_W-1:0] n);
    logic [2*IDX_W-1:0] t;
    logic [2*IDX_W-1:0] r;
    t = {{IDX_W{1'b0}}, a} + ({{IDX_W{1'b0}}, n} << LAG_W)
        - {{(2*IDX_W-LAG_W){1'b0}}, b};
    r = t % {{IDX_W{1'b0}}, n};
    return r[IDX_W-1:0];
  endfunction

  // base + idx * stride, wrapping in the address width
  function automatic logic [ADDR_W-1:0] frame_base(input logic [ADDR_W-1:0] base,
                                                    input logic [IDX_W-1:0]  idx,
                                                    input logic [ADDR_W-1:0] stride);
    logic [ADDR_W-1:0] off;
    off = stride * {{(ADDR_W-IDX_W){1'b0}}, idx};
    return base + off;
  endfunction

endpackage

// File: rtl/frs_writer_sel.sv
module frs_writer_sel
  import frame_ring_pkg::*;
(
  input  logic             lock_en,
  input  logic             role_reader,
  input  logic             dyn_mode,
  input  logic [IDX_W-1:0] n_eff,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] peer_idx,
  input  logic             frame_done,
  output logic             w_load,
  output logic [IDX_W-1:0] w_val
);

  logic [IDX_W-1:0] first_step;
  logic [IDX_W-1:0] second_step;
  logic             hits_reader;

  always_comb begin
    first_step  = ring_step(cur_idx, n_eff);
    second_step = ring_step(first_step, n_eff);
    hits_reader = dyn_mode && (n_eff > {{(IDX_W-1){1'b0}}, 1'b1})
                  && (first_step == peer_idx);
    w_val       = hits_reader ? second_step : first_step;
    w_load      = lock_en && !role_reader && frame_done;
  end

endmodule

// File: rtl/frs_reader_sel.sv
module frs_reader_sel
  import frame_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic             role_reader,
  input  logic             dyn_mode,
  input  logic             wait_writer,
  input  logic [IDX_W-1:0] n_eff,
  input  logic [LAG_W-1:0] lag,
  input  logic [IDX_W-1:0] peer_idx,
  input  logic             peer_valid,
  input  logic             frame_start,
  output logic             r_load,
  output logic [IDX_W-1:0] r_val,
  output logic             start_ok
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] fill_need;
  logic             filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fill_cnt <= '0;
    else if (!lock_en)
      fill_cnt <= '0;
    else if (peer_valid && fill_cnt != CNT_MAX)
      fill_cnt <= fill_cnt + 1'b1;
  end

  always_comb begin
    fill_need = {{(CNT_W-LAG_W){1'b0}}, lag} + {{(CNT_W-1){1'b0}}, 1'b1};
    filled    = fill_cnt >= fill_need;
    if (!lock_en || !role_reader || !wait_writer)
      start_ok = 1'b1;
    else
      start_ok = filled;
    r_val  = dyn_mode ? peer_idx : ring_back(peer_idx, lag, n_eff);
    r_load = lock_en && role_reader && frame_start && start_ok;
  end

  // R8: a writer is never held back
  a_r8_writer_free: assert property (@(posedge clk) disable iff (!rst_n)
    !role_reader |-> start_ok);

  // R7: the hold releases only after a writer completion has been counted
  a_r7_release_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && role_reader && wait_writer && $rose(start_ok)
     && $stable(lag) && $stable(lock_en) && $stable(wait_writer) && $stable(role_reader))
    |-> $past(peer_valid));

endmodule

// File: rtl/frs_addr_gen.sv
module frs_addr_gen
  import frame_ring_pkg::*;
(
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] frame_stride,
  input  logic [IDX_W-1:0]  buf_idx,
  output logic [ADDR_W-1:0] frame_addr
);

  always_comb frame_addr = frame_base(base_addr, buf_idx, frame_stride);

  // R9: buffer 0 always sits on the base address
  always_comb begin
    if (buf_idx == '0)
      a_r9_zero_at_base: assert (frame_addr == base_addr);
  end

endmodule

// File: rtl/frame_ring_sched.sv
module frame_ring_sched
  import frame_ring_pkg::*;
#(
  parameter int MAX_BUFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic              role_reader,
  input  logic              dyn_mode,
  input  logic              wait_writer,
  input  logic [IDX_W-1:0]  num_bufs,
  input  logic [LAG_W-1:0]  lag,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] frame_stride,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic [IDX_W-1:0]  peer_idx,
  input  logic              peer_valid,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [ADDR_W-1:0] frame_addr,
  output logic              start_ok
);

  localparam logic [IDX_W-1:0] MAX_N = IDX_W'(MAX_BUFS);

  logic [IDX_W-1:0] n_eff;
  logic             w_load;
  logic [IDX_W-1:0] w_val;
  logic             r_load;
  logic [IDX_W-1:0] r_val;

  always_comb n_eff = ring_size(num_bufs, MAX_N);

  frs_writer_sel u_wsel (
    .lock_en     (lock_en),
    .role_reader (role_reader),
    .dyn_mode    (dyn_mode),
    .n_eff       (n_eff),
    .cur_idx     (buf_idx),
    .peer_idx    (peer_idx),
    .frame_done  (frame_done),
    .w_load      (w_load),
    .w_val       (w_val)
  );

  frs_reader_sel u_rsel (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_en     (lock_en),
    .role_reader (role_reader),
    .dyn_mode    (dyn_mode),
    .wait_writer (wait_writer),
    .n_eff       (n_eff),
    .lag         (lag),
    .peer_idx    (peer_idx),
    .peer_valid  (peer_valid),
    .frame_start (frame_start),
    .r_load      (r_load),
    .r_val       (r_val),
    .start_ok    (start_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      buf_idx <= '0;
    else if (!lock_en)
      buf_idx <= '0;
    else if (w_load)
      buf_idx <= w_val;
    else if (r_load)
      buf_idx <= r_val;
  end

  frs_addr_gen u_addr (
    .base_addr    (base_addr),
    .frame_stride (frame_stride),
    .buf_idx      (buf_idx),
    .frame_addr   (frame_addr)
  );

  // R2: a disabled lock parks the ring on buffer 0
  a_r2_park_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> buf_idx == '0);

  // R4: a dynamic writer never lands on the reader's buffer
  a_r4_skip_reader: assert property (@(posedge clk) disable iff (!rst_n)
    (w_load && dyn_mode && n_eff > 6'd1 && peer_idx < n_eff) |=> buf_idx != $past(peer_idx));

  // R6: a dynamic reader takes the newest finished buffer
  a_r6_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (r_load && dyn_mode) |=> buf_idx == $past(peer_idx));

  // R7: a held reader ignores frame starts
  a_r7_hold_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && role_reader && !start_ok && frame_start) |=> $stable(buf_idx));

  // R3: a writer step always stays inside the ring
  a_r3_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (w_load && !dyn_mode) |=> buf_idx < $past(n_eff));

endmodule

// File: tb/test_frame_ring_sched.sv
`timescale 1ns/1ps
module test_frame_ring_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lock_en, role_reader, dyn_mode, wait_writer;
  logic [5:0]  num_bufs;
  logic [4:0]  lag;
  logic [31:0] base_addr, frame_stride;
  logic        frame_start, frame_done, peer_valid;
  logic [5:0]  peer_idx;
  logic [5:0]  buf_idx;
  logic [31:0] frame_addr;
  logic        start_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_ring_sched #(.MAX_BUFS(16)) i_frame_ring_sched (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .role_reader(role_reader),
    .dyn_mode(dyn_mode), .wait_writer(wait_writer), .num_bufs(num_bufs), .lag(lag),
    .base_addr(base_addr), .frame_stride(frame_stride), .frame_start(frame_start),
    .frame_done(frame_done), .peer_idx(peer_idx), .peer_valid(peer_valid),
    .buf_idx(buf_idx), .frame_addr(frame_addr), .start_ok(start_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected address by repeated addition
  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [5:0] i,
                                           input logic [31:0] s);
    logic [31:0] a = b;
    for (int k = 0; k < int'(i); k++) a = a + s;
    return a;
  endfunction

  // fields: role dyn n[6] lag[5] peer[6] ev[2] (1=done,2=start) exp[6]
  localparam int NV = 18;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,6'd4, 5'd0,6'd0, 2'd1,6'd1},   // R3
    {1'b0,1'b0,6'd4, 5'd0,6'd0, 2'd1,6'd2},   // R3
    {1'b0,1'b0,6'd4, 5'd0,6'd0, 2'd1,6'd3},   // R3
    {1'b0,1'b0,6'd4, 5'd0,6'd0, 2'd1,6'd0},   // R3 wrap
    {1'b0,1'b1,6'd4, 5'd0,6'd1, 2'd1,6'd2},   // R4 skip
    {1'b0,1'b1,6'd4, 5'd0,6'd3, 2'd1,6'd0},   // R4 skip across wrap
    {1'b0,1'b1,6'd4, 5'd0,6'd2, 2'd1,6'd1},   // R4 no collision
    {1'b0,1'b0,6'd1, 5'd0,6'd0, 2'd1,6'd0},   // R3 single buffer
    {1'b1,1'b0,6'd5, 5'd2,6'd1, 2'd2,6'd4},   // R5 wrap back
    {1'b1,1'b0,6'd5, 5'd0,6'd3, 2'd2,6'd3},   // R5 lag 0
    {1'b1,1'b0,6'd5, 5'd3,6'd4, 2'd2,6'd1},   // R5 oldest
    {1'b1,1'b1,6'd5, 5'd3,6'd2, 2'd2,6'd2},   // R6
    {1'b1,1'b1,6'd5, 5'd3,6'd4, 2'd2,6'd4},   // R6
    {1'b1,1'b1,6'd5, 5'd3,6'd4, 2'd1,6'd4},   // R10 reader ignores done
    {1'b0,1'b0,6'd5, 5'd0,6'd0, 2'd2,6'd4},   // R10 writer ignores start
    {1'b0,1'b0,6'd5, 5'd0,6'd0, 2'd1,6'd0},   // R3
    {1'b0,1'b0,6'd0, 5'd0,6'd0, 2'd1,6'd0},   // R3 size 0 as 1
    {1'b1,1'b0,6'd40,5'd0,6'd20,2'd2,6'd4}    // R3 clamp to 16
  };

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lock_en = 1'b1; role_reader = 1'b0; dyn_mode = 1'b0; wait_writer = 1'b0;
    num_bufs = 6'd4; lag = '0; base_addr = 32'h1000_0000; frame_stride = 32'h0001_2000;
    frame_start = 1'b0; frame_done = 1'b0; peer_idx = '0; peer_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idx in reset", 32'(buf_idx), 32'd0);
    chk("R1 addr in reset", frame_addr, 32'h1000_0000);
    chk("R1 start_ok in reset", 32'(start_ok), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idx after reset", 32'(buf_idx), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [26:0] e;
      e = VEC[v];
      @(negedge clk);
      role_reader = e[26]; dyn_mode = e[25]; num_bufs = e[24:19];
      lag = e[18:14]; peer_idx = e[13:8];
      frame_done = e[6]; frame_start = e[7];
      @(negedge clk);
      frame_done = 1'b0; frame_start = 1'b0;
      chk($sformatf("R3/R4/R5/R6/R10 idx vec %0d", v), 32'(buf_idx), 32'(e[5:0]));
      chk($sformatf("R9 addr vec %0d", v), frame_addr,
          exp_addr(base_addr, e[5:0], frame_stride));
      if (!e[26]) chk($sformatf("R8 writer start_ok vec %0d", v), 32'(start_ok), 32'd1);
    end

    // R2: lock off parks on 0 and ignores done
    @(negedge clk);
    role_reader = 1'b0; lock_en = 1'b0; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R2 idx parked", 32'(buf_idx), 32'd0);
    chk("R2 start_ok when off", 32'(start_ok), 32'd1);

    // R7: reader start-up hold, lag 1 needs two writer completions
    role_reader = 1'b1; dyn_mode = 1'b0; num_bufs = 6'd4; lag = 5'd1;
    wait_writer = 1'b1; lock_en = 1'b1; peer_idx = 6'd2;
    @(negedge clk);
    chk("R7 held at start", 32'(start_ok), 32'd0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R7 start ignored while held", 32'(buf_idx), 32'd0);
    peer_valid = 1'b1;
    @(negedge clk);
    peer_valid = 1'b0;
    chk("R7 still held after one fill", 32'(start_ok), 32'd0);
    peer_valid = 1'b1; frame_start = 1'b1;
    @(negedge clk);
    peer_valid = 1'b0; frame_start = 1'b0;
    chk("R7 same-cycle start ignored", 32'(buf_idx), 32'd0);
    chk("R7 released after lag+1 fills", 32'(start_ok), 32'd1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R7 R5 first pick after release", 32'(buf_idx), 32'd1);

    // R9: address wraps in 32 bits
    base_addr = 32'hFFFF_F000; frame_stride = 32'h0000_3000;
    #1;
    chk("R9 address wrap", frame_addr, 32'h0000_2000);

    // R8: without wait the reader may start at once
    @(negedge clk);
    lock_en = 1'b0;
    @(negedge clk);
    wait_writer = 1'b0; lock_en = 1'b1;
    @(negedge clk);
    chk("R8 reader free without wait", 32'(start_ok), 32'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule